// File: doc/BRIEF.md
# UART Receive Interrupt Identifier

This block ranks the receive-side interrupt causes of a 16550-style serial port and presents the winner as an 8-bit identification byte with an interrupt request line. It records three causes. A line-status event is raised by overrun, parity, framing or break. A data-ready event follows the receive buffer, or the FIFO trigger level when the FIFO is on. A character timeout is raised when the receive FIFO has been idle but not empty for four character times.

Each cause has its own way of being cleared. The line event clears on a line-status read. The data event clears on a receive-buffer read or when the FIFO level falls below the trigger. The timeout clears on a receive-buffer read. While the CPU is reading the identification byte, the byte it sees is held still. Causes that arrive during the read are recorded and appear once the read ends.

Top module: `uart_rx_irq_id`

## Requirements
- R1: With no enabled cause pending, bit 0 of `iirValue` is 1 and bits 3:1 are 0, so the idle byte is 8'h01 with the FIFO off and 8'hC1 with it on. With any enabled cause pending, bit 0 is 0.
- R2: Bits 2:1 name the winning cause in fixed priority order. Line status is highest with 2'b11. Data ready comes next with 2'b10. Timeout is last with 2'b10 and bit 3 set. Data ready therefore hides a pending timeout.
- R3: Bit 3 is 1 only in FIFO mode and only while a timeout is the reported cause. With the FIFO off it is always 0.
- R4: Bits 5:4 always read 0. Bits 7:6 both equal `fifoEn`.
- R5: A pulse on any bit of `lineErr` sets the line cause. Only an `rdLsr` strobe clears it.
- R6: The data cause is pending while `rxAtTrigger` is 1. It drops when `rxAtTrigger` falls or in a cycle where `rdRbr` is strobed.
- R7: The timeout cause is raised on the fourth `charTick` counted while the FIFO is enabled and not empty. A `fifoPush`, `fifoPop` or `rdRbr` restarts the count from zero.
- R8: The timeout cause is cleared by `rdRbr`, and also when the FIFO empties or FIFO mode is turned off. The count is held at zero while the FIFO is empty or FIFO mode is off.
- R9: While `rdIir` is 1, `iirValue` does not change. After `rdIir` returns to 0, the value reflects the causes recorded meanwhile.
- R10: A cause whose enable is 0 never shows in `iirValue` or `irq`. The cause is still recorded, and it appears as soon as its enable returns to 1. `enDataIrq` covers both the data cause and the timeout.
- R11: `irq` is 1 exactly when an enabled cause is pending. Unlike `iirValue`, it is not held during `rdIir`.
- R12: After reset, `iirValue` is 8'h01 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | FIFO mode enable |
| lineErr | input | 4 | Overrun, parity, framing and break event pulses |
| rxAtTrigger | input | 1 | Receive level at or above the trigger (buffer full when the FIFO is off) |
| rxEmpty | input | 1 | Receive FIFO holds no characters |
| fifoPush | input | 1 | A character entered the receive FIFO |
| fifoPop | input | 1 | A character left the receive FIFO |
| charTick | input | 1 | One pulse per character time |
| rdIir | input | 1 | CPU read of the identification byte in progress |
| rdLsr | input | 1 | CPU read of the line-status register |
| rdRbr | input | 1 | CPU read of the receive buffer |
| enLineIrq | input | 1 | Enable for the line-status cause |
| enDataIrq | input | 1 | Enable for the data and timeout causes |
| iirValue | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every stimulus is latched into the cause registers at the first rising edge. It reaches `iirValue` and `irq` at the second rising edge. The scoreboard therefore stamps each expected item two cycles ahead and compares it at the falling edge of that cycle, after both registers have settled.

For R9, the item is stamped while `rdIir` is still held high. The old byte is expected together with the new `irq`. A second item is stamped after the release.

Timeout items are queued only after the final `charTick` pulse. This counts the fourth tick as the first of the two edges.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  typedef struct packed {
    logic cntRestart;
    logic cntHoldZero;
    logic cntTick;
    logic lineSet;
    logic lineClr;
    logic dataNext;
    logic toClr;
    logic iirLoad;
  } uirq_strobes_t;

  localparam logic [1:0] ID_LINE = 2'b11;
  localparam logic [1:0] ID_DATA = 2'b10;
  localparam logic [7:0] IIR_IDLE = 8'h01;

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             fifoEn,
  input  logic [ERR_W-1:0] lineErr,
  input  logic             rxAtTrigger,
  input  logic             rxEmpty,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic             charTick,
  input  logic             rdIir,
  input  logic             rdLsr,
  input  logic             rdRbr,
  output uirq_strobes_t    strobes
);

  logic [ERR_W:0] errChain;
  assign errChain[0] = 1'b0;

  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    assign errChain[i+1] = errChain[i] | lineErr[i];
  end

  always_comb begin
    strobes.lineSet     = errChain[ERR_W];
    strobes.lineClr     = rdLsr;
    strobes.dataNext    = rxAtTrigger & ~rdRbr;
    strobes.cntRestart  = fifoPush | fifoPop | rdRbr;
    strobes.cntHoldZero = rxEmpty | ~fifoEn;
    strobes.cntTick     = charTick;
    strobes.toClr       = rdRbr | rxEmpty | ~fifoEn;
    strobes.iirLoad     = ~rdIir;
  end

endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int TO_CHARS = 4,
  localparam int CNT_W = $clog2(TO_CHARS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  uirq_strobes_t strobes,
  input  logic          fifoEn,
  input  logic          enLineIrq,
  input  logic          enDataIrq,
  output logic [7:0]    iirValue,
  output logic          irq
);

  logic [CNT_W-1:0] idleCnt;
  logic linePend, dataPend, toPend;
  logic toFire;
  logic lineVis, dataVis, toVis, anyVis;
  logic [7:0] iirNext;

  assign toFire = ~strobes.cntHoldZero & ~strobes.cntRestart & strobes.cntTick
                  & (idleCnt == CNT_W'(TO_CHARS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (strobes.cntHoldZero || strobes.cntRestart) begin
      idleCnt <= '0;
    end else if (strobes.cntTick && idleCnt != CNT_W'(TO_CHARS)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linePend <= 1'b0;
      dataPend <= 1'b0;
      toPend   <= 1'b0;
    end else begin
      if (strobes.lineSet)      linePend <= 1'b1;
      else if (strobes.lineClr) linePend <= 1'b0;
      dataPend <= strobes.dataNext;
      if (toFire)               toPend <= 1'b1;
      else if (strobes.toClr)   toPend <= 1'b0;
    end
  end

  assign lineVis = linePend & enLineIrq;
  assign dataVis = dataPend & enDataIrq;
  assign toVis   = toPend & enDataIrq & fifoEn;
  assign anyVis  = lineVis | dataVis | toVis;

  always_comb begin
    iirNext      = IIR_IDLE;
    iirNext[7:6] = {fifoEn, fifoEn};
    if (lineVis) begin
      iirNext[3:0] = {1'b0, ID_LINE, 1'b0};
    end else if (dataVis) begin
      iirNext[3:0] = {1'b0, ID_DATA, 1'b0};
    end else if (toVis) begin
      iirNext[3:0] = {1'b1, ID_DATA, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iirValue <= IIR_IDLE;
      irq      <= 1'b0;
    end else begin
      if (strobes.iirLoad) iirValue <= iirNext;
      irq <= anyVis;
    end
  end

endmodule

// File: rtl/uart_rx_irq_id.sv
module uart_rx_irq_id
  import uirq_pkg::*;
#(
  parameter int ERR_W    = 4,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifoEn,
  input  logic [ERR_W-1:0] lineErr,
  input  logic             rxAtTrigger,
  input  logic             rxEmpty,
  input  logic             fifoPush,
  input  logic             fifoPop,
  input  logic             charTick,
  input  logic             rdIir,
  input  logic             rdLsr,
  input  logic             rdRbr,
  input  logic             enLineIrq,
  input  logic             enDataIrq,
  output logic [7:0]       iirValue,
  output logic             irq
);

  uirq_strobes_t strobes;

  uirq_ctrl #(.ERR_W(ERR_W)) u_ctrl (
    .fifoEn(fifoEn), .lineErr(lineErr), .rxAtTrigger(rxAtTrigger),
    .rxEmpty(rxEmpty), .fifoPush(fifoPush), .fifoPop(fifoPop),
    .charTick(charTick), .rdIir(rdIir), .rdLsr(rdLsr), .rdRbr(rdRbr),
    .strobes(strobes)
  );

  uirq_datapath #(.TO_CHARS(TO_CHARS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .fifoEn(fifoEn),
    .enLineIrq(enLineIrq), .enDataIrq(enDataIrq),
    .iirValue(iirValue), .irq(irq)
  );

endmodule

// File: rtl/uirq_checker.sv
module uirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rdIir,
  input logic [7:0] iirValue,
  input logic       irq
);

  p_idle_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iirValue[0] |-> (iirValue[3:1] == 3'b000));

  p_timeout_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iirValue[3] |-> (iirValue[7:6] == 2'b11 && iirValue[2:0] == 3'b100));

  p_fixed_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iirValue[5:4] == 2'b00) && (iirValue[7] == iirValue[6]));

  p_frozen_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rdIir) |-> $stable(iirValue));

  p_irq_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdIir) |-> (irq == !iirValue[0]));

endmodule

bind uart_rx_irq_id uirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rdIir(rdIir), .iirValue(iirValue), .irq(irq)
);

// File: tb/uart_rx_irq_id_bench.sv
module uart_rx_irq_id_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifoEn = 0, rxAtTrigger = 0, rxEmpty = 1, fifoPush = 0, fifoPop = 0;
  logic charTick = 0, rdIir = 0, rdLsr = 0, rdRbr = 0;
  logic enLineIrq = 1, enDataIrq = 1;
  logic [3:0] lineErr = '0;
  logic [7:0] iirValue;
  logic irq;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [7:0] iir;
    logic       irq;
    string      tag;
  } sb_item_t;

  sb_item_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_irq_id u_uart_rx_irq_id (
    .clk(clk), .rst_n(rst_n), .fifoEn(fifoEn), .lineErr(lineErr),
    .rxAtTrigger(rxAtTrigger), .rxEmpty(rxEmpty), .fifoPush(fifoPush),
    .fifoPop(fifoPop), .charTick(charTick), .rdIir(rdIir), .rdLsr(rdLsr),
    .rdRbr(rdRbr), .enLineIrq(enLineIrq), .enDataIrq(enDataIrq),
    .iirValue(iirValue), .irq(irq)
  );

  // monitor: compares due items at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      sb_item_t it;
      it = sbq.pop_front();
      total++;
      if (iirValue !== it.iir || irq !== it.irq) begin
        bad++;
        $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                 it.tag, iirValue, irq, it.iir, it.irq);
      end
    end
  end

  task automatic nxt(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(logic [7:0] iir, logic q, string tag, int wait_n = 3);
    sb_item_t it;
    it.due = cyc + 2; it.iir = iir; it.irq = q; it.tag = tag;
    sbq.push_back(it);
    nxt(wait_n);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      charTick = 1; nxt(); charTick = 0; nxt();
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
    end
  end

  initial begin
    nxt(3);
    rst_n = 1;
    expect_out(8'h01, 0, "R12 reset state");
    expect_out(8'h01, 0, "R1 idle non-FIFO");

    fifoEn = 1;
    expect_out(8'hC1, 0, "R4 FIFO-mode idle bits 7:6");

    // non-FIFO data and line status
    fifoEn = 0; rxEmpty = 0; rxAtTrigger = 1;
    expect_out(8'h04, 1, "R6 data ready");
    lineErr = 4'b0010; nxt(); lineErr = '0;
    expect_out(8'h06, 1, "R2 line over data");
    nxt(5);
    expect_out(8'h06, 1, "R5 line held without LSR read");
    rdRbr = 1; rxAtTrigger = 0; nxt(); rdRbr = 0;
    expect_out(8'h06, 1, "R5 buffer read leaves line cause");
    rdLsr = 1; nxt(); rdLsr = 0;
    expect_out(8'h01, 0, "R5 cleared by LSR read");

    // freeze during identification read
    rdIir = 1; nxt();
    lineErr = 4'b1000; nxt(); lineErr = '0;
    expect_out(8'h01, 1, "R9 frozen value, R11 irq live");
    rdIir = 0;
    expect_out(8'h06, 1, "R9 update after read");
    rdLsr = 1; nxt(); rdLsr = 0;
    expect_out(8'h01, 0, "R5 clear after freeze");

    // masking
    enLineIrq = 0;
    lineErr = 4'b0001; nxt(); lineErr = '0;
    expect_out(8'h01, 0, "R10 masked line cause hidden");
    enLineIrq = 1;
    expect_out(8'h06, 1, "R10 recorded cause appears");
    rdLsr = 1; nxt(); rdLsr = 0;
    enDataIrq = 0; rxAtTrigger = 1;
    expect_out(8'h01, 0, "R10 masked data cause");
    enDataIrq = 1; rxAtTrigger = 0;
    expect_out(8'h01, 0, "R6 level drop clears data");

    // character timeout in FIFO mode
    fifoEn = 1; rxEmpty = 0;
    fifoPush = 1; nxt(); fifoPush = 0; nxt();
    ticks(3);
    expect_out(8'hC1, 0, "R7 no timeout after 3 ticks");
    fifoPop = 1; nxt(); fifoPop = 0; nxt();
    ticks(3);
    expect_out(8'hC1, 0, "R7 pop restarts count");
    ticks(1);
    expect_out(8'hCC, 1, "R7 timeout on fourth tick", 1);
    nxt(5);
    expect_out(8'hCC, 1, "R3 timeout held, bit 3 set");
    rdRbr = 1; fifoPop = 1; nxt(); rdRbr = 0; fifoPop = 0;
    expect_out(8'hC1, 0, "R8 timeout cleared by buffer read");
    ticks(4);
    expect_out(8'hCC, 1, "R7 timeout again");
    rxAtTrigger = 1;
    expect_out(8'hC4, 1, "R2 data hides timeout");
    rxAtTrigger = 0;
    expect_out(8'hCC, 1, "R6 trigger drop leaves timeout");
    rxEmpty = 1;
    expect_out(8'hC1, 0, "R8 empty clears timeout");
    ticks(6);
    expect_out(8'hC1, 0, "R8 count held while empty");
    rxEmpty = 0; fifoEn = 0;
    ticks(6);
    expect_out(8'h01, 0, "R3 no timeout with FIFO off");

    nxt(4);
    done = 1;
    report();
  end

endmodule